// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block reshapes the second operand of a processor datapath before it reaches the ALU. It takes a word-wide operand, a 2-bit shift kind, a shift distance and the current carry flag. In the same cycle it returns the shifted word and a carry-out flag. The distance is already decoded upstream, either from an immediate field or from the low bits of a register. The block holds no state.

Four kinds are available: logical left, logical right, arithmetic right and rotate right. A rotate with distance zero is not a no-op. It becomes a one-place rotate through the carry flag. Every nonzero shift reports the last bit that left the operand as its carry-out.

The datapath is a logarithmic tree of single-distance stages. Left shifts reuse the same right-shifting tree by bit-reversing the word before the tree and again after it. The language shift operators are not used on the variable distance.

Top module: `barrel_shift_unit`

## Requirements
- R1: With kind 2'b00 (left) and a nonzero distance n, bits move toward the MSB by n places and the n low bits become zero. For example, 0x92345678 with n=8 gives 0x34567800.
- R2: With kind 2'b01 (logical right) and a nonzero distance n, bits move toward the LSB by n places and the n high bits become zero. For example, 0x92345678 with n=8 gives 0x00923456.
- R3: With kind 2'b10 (arithmetic right) and a nonzero distance n, the n high bits become copies of the operand's bit W-1. Negative values therefore round toward minus infinity: 0xFFFFFFFB with n=2 gives 0xFFFFFFFE.
- R4: With kind 2'b11 (rotate right) and a nonzero distance n, bits that leave bit 0 re-enter at bit W-1. For example, 0x92345678 with n=8 gives 0x78923456.
- R5: With kind 2'b11 and distance 0, the result is the operand moved right by exactly one place, with the carry-in placed in bit W-1. The carry-out is the operand's bit 0.
- R6: For any kind with a nonzero distance, the carry-out is the last bit shifted out. For left shifts that is operand bit W-n. For the three right kinds it is operand bit n-1.
- R7: With distance 0 and kind 2'b00, 2'b01 or 2'b10, the result equals the operand and the carry-out equals the carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_in | input | W (32) | Operand to be shifted |
| kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right / rotate through carry |
| amt | input | AW (5) | Shift distance, 0 to W-1 |
| c_in | input | 1 | Carry flag in |
| res_out | output | W (32) | Shifted operand |
| c_out | output | 1 | Carry flag out |

## Verification
The bench sweeps every distance from 0 to 31 in all four kinds. It uses pseudo-random operands plus all-zero, all-one, sign-only and LSB-only words, and compares each result against a bit-at-a-time reference.

The distance-zero cases get the closest attention:
- A design that treats a zero rotate as a plain pass-through would leave bit 31 and the carry wrong.
- A design that takes carry from the shifter path at distance zero would drop the incoming flag.

The negative arithmetic case catches zero filling in place of sign filling. Carry checks at distances 1 and 31 catch an off-by-one in the tap position, in particular a left-shift carry taken from the mirrored index on the wrong side.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_kind_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_SIGN = 2'b01,
    FILL_WRAP = 2'b10
  } fill_e;

endpackage

// File: rtl/bsh_mirror.sv
module bsh_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         flip,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = flip ? din[W-1-i] : din[i];
  end

endmodule

// File: rtl/bsh_stage.sv
module bsh_stage #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0]   din,
  input  logic           en,
  input  bsh_pkg::fill_e fill,
  input  logic           sign,
  output logic [W-1:0]   dout
);
  import bsh_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic moved;
    if (i + DIST < W) begin : g_inner
      // source still inside the word
      assign moved = din[i + DIST];
    end else begin : g_edge
      // vacated position: choose the fill
      always_comb begin
        unique case (fill)
          FILL_SIGN: moved = sign;
          FILL_WRAP: moved = din[i + DIST - W];
          default:   moved = 1'b0;
        endcase
      end
    end
    assign dout[i] = en ? moved : din[i];
  end

endmodule

// File: rtl/bsh_rtree.sv
module bsh_rtree #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [AW-1:0]  amt,
  input  bsh_pkg::fill_e fill,
  input  logic           sign,
  output logic [W-1:0]   dout
);

  logic [W-1:0] lvl [AW+1];

  assign lvl[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    bsh_stage #(
      .W    (W),
      .DIST (1 << k)
    ) u_stage (
      .din  (lvl[k]),
      .en   (amt[k]),
      .fill (fill),
      .sign (sign),
      .dout (lvl[k+1])
    );
  end

  assign dout = lvl[AW];

endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  op_in,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          c_in,
  output logic [W-1:0]  res_out,
  output logic          c_out
);
  import bsh_pkg::*;

  sh_kind_e      kind_e;
  logic          go_left;
  logic          amt_zero;
  logic          thru_carry;
  fill_e         fill_sel;
  logic [W-1:0]  pre_word;
  logic [W-1:0]  tree_word;
  logic [W-1:0]  post_word;
  logic [AW-1:0] tap_idx;
  logic          tap_bit;

  assign kind_e     = sh_kind_e'(kind);
  assign go_left    = (kind_e == SH_LSL);
  assign amt_zero   = (amt == '0);
  assign thru_carry = (kind_e == SH_ROR) && amt_zero;

  always_comb begin
    unique case (kind_e)
      SH_ASR:  fill_sel = FILL_SIGN;
      SH_ROR:  fill_sel = FILL_WRAP;
      default: fill_sel = FILL_ZERO;
    endcase
  end

  bsh_mirror #(.W(W)) u_pre (
    .din  (op_in),
    .flip (go_left),
    .dout (pre_word)
  );

  bsh_rtree #(.W(W), .AW(AW)) u_tree (
    .din  (pre_word),
    .amt  (amt),
    .fill (fill_sel),
    .sign (op_in[W-1]),
    .dout (tree_word)
  );

  bsh_mirror #(.W(W)) u_post (
    .din  (tree_word),
    .flip (go_left),
    .dout (post_word)
  );

  // last bit out sits at n-1 of the (possibly mirrored) input word
  assign tap_idx = amt - AW'(1);
  assign tap_bit = pre_word[tap_idx];

  always_comb begin
    if (thru_carry) begin
      res_out = {c_in, op_in[W-1:1]};
      c_out   = op_in[0];
    end else if (amt_zero) begin
      res_out = op_in;
      c_out   = c_in;
    end else begin
      res_out = post_word;
      c_out   = tap_bit;
    end
  end

endmodule

// File: rtl/bsh_chk.sv
module bsh_chk #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input logic [W-1:0]  op_in,
  input logic [1:0]    kind,
  input logic [AW-1:0] amt,
  input logic          c_in,
  input logic [W-1:0]  res_out,
  input logic          c_out
);

  logic known;
  assign known = !$isunknown({op_in, kind, amt, c_in, res_out, c_out});

  always_comb begin
    if (known) begin
      // R1
      lsl_low_zero_chk: assert (!(kind == 2'b00 && amt != '0) ||
                                (res_out[0] == 1'b0));
      // R2
      lsr_high_zero_chk: assert (!(kind == 2'b01 && amt != '0) ||
                                 (res_out[W-1] == 1'b0));
      // R3
      asr_sign_keep_chk: assert (!(kind == 2'b10) ||
                                 (res_out[W-1] == op_in[W-1]));
      // R4
      ror_count_chk: assert (!(kind == 2'b11 && amt != '0) ||
                             ($countones(res_out) == $countones(op_in)));
      // R5
      rrx_chk: assert (!(kind == 2'b11 && amt == '0) ||
                       (res_out[W-1] == c_in && c_out == op_in[0] &&
                        res_out[W-2:0] == op_in[W-1:1]));
      // R6
      lsl_carry_chk: assert (!(kind == 2'b00 && amt != '0) ||
                             (c_out == op_in[W - int'(amt)]));
      // R6
      rshift_carry_chk: assert (!(kind != 2'b00 && amt != '0) ||
                                (c_out == op_in[int'(amt) - 1]));
      // R7
      zero_pass_chk: assert (!(kind != 2'b11 && amt == '0) ||
                             (res_out == op_in && c_out == c_in));
    end
  end

endmodule

bind barrel_shift_unit bsh_chk #(.W(W), .AW(AW)) u_chk (
  .op_in   (op_in),
  .kind    (kind),
  .amt     (amt),
  .c_in    (c_in),
  .res_out (res_out),
  .c_out   (c_out)
);

// File: tb/sim_barrel_shift_unit.sv
module sim_barrel_shift_unit;

  logic        clk;
  logic        rst_n;
  logic [31:0] op_in;
  logic [1:0]  kind;
  logic [4:0]  amt;
  logic        c_in;
  logic [31:0] res_out;
  logic        c_out;

  int total;
  int bad;
  bit done;
  logic [31:0] seed;

  barrel_shift_unit u0 (
    .op_in   (op_in),
    .kind    (kind),
    .amt     (amt),
    .c_in    (c_in),
    .res_out (res_out),
    .c_out   (c_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: move one bit per step
  function automatic logic [32:0] ref_shift(logic [31:0] v, int t, int n, logic c);
    logic [31:0] w;
    logic        cy;
    w  = v;
    cy = c;
    if (t == 3 && n == 0) begin
      cy = v[0];
      w  = {c, v[31:1]};
    end else begin
      for (int s = 0; s < n; s++) begin
        case (t)
          0: begin cy = w[31]; w = {w[30:0], 1'b0}; end
          1: begin cy = w[0];  w = {1'b0, w[31:1]}; end
          2: begin cy = w[0];  w = {w[31], w[31:1]}; end
          default: begin cy = w[0]; w = {w[0], w[31:1]}; end
        endcase
      end
    end
    return {cy, w};
  endfunction

  function automatic string res_tag(int t, int n);
    if (t == 3 && n == 0) return "R5";
    if (n == 0) return "R7";
    case (t)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic string cy_tag(int t, int n);
    if (t == 3 && n == 0) return "R5";
    if (n == 0) return "R7";
    return "R6";
  endfunction

  task automatic apply(logic [31:0] v, int t, int n, logic c);
    logic [32:0] exp;
    @(posedge clk);
    op_in = v;
    kind  = 2'(t);
    amt   = 5'(n);
    c_in  = c;
    exp   = ref_shift(v, t, n, c);
    @(negedge clk);
    total++;
    if (res_out !== exp[31:0]) begin
      bad++;
      $display("FAIL %s result op=%h kind=%0d amt=%0d cin=%b actual=%h expected=%h",
               res_tag(t, n), v, t, n, c, res_out, exp[31:0]);
    end
    total++;
    if (c_out !== exp[32]) begin
      bad++;
      $display("FAIL %s carry op=%h kind=%0d amt=%0d cin=%b actual=%b expected=%b",
               cy_tag(t, n), v, t, n, c, c_out, exp[32]);
    end
  endtask

  task automatic expect_word(string tag, logic [31:0] exp);
    total++;
    if (res_out !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, res_out, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    total = 0;
    bad   = 0;
    done  = 0;
    seed  = 32'h1234_5679;
    rst_n = 1'b0;
    op_in = '0;
    kind  = '0;
    amt   = '0;
    c_in  = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R7: idle inputs give a zero word and zero carry
    total++;
    if (res_out !== 32'h0 || c_out !== 1'b0) begin
      bad++;
      $display("FAIL R7 reset actual=%h/%b expected=00000000/0", res_out, c_out);
    end
    rst_n = 1'b1;

    // directed examples
    apply(32'h9234_5678, 0, 8, 1'b0); expect_word("R1", 32'h3456_7800);
    apply(32'h9234_5678, 1, 8, 1'b0); expect_word("R2", 32'h0092_3456);
    apply(32'h9234_5678, 3, 8, 1'b0); expect_word("R4", 32'h7892_3456);
    apply(32'hFFFF_FFFB, 2, 2, 1'b0); expect_word("R3", 32'hFFFF_FFFE);
    apply(32'h0000_0005, 2, 2, 1'b1); expect_word("R3", 32'h0000_0001);
    apply(32'h0000_0003, 3, 0, 1'b1); expect_word("R5", 32'h8000_0001);
    apply(32'h8000_0000, 0, 1, 1'b0);   // R6 carry from bit 31
    apply(32'h0000_0001, 1, 31, 1'b0);  // R6 carry from bit 30 is 0
    apply(32'h4000_0000, 1, 31, 1'b0);  // R6 carry from bit 30 is 1

    // R7 zero-distance pass-through with both carry values
    for (int t = 0; t < 3; t++) begin
      apply(32'hA5A5_0F0F, t, 0, 1'b1);
      apply(32'hA5A5_0F0F, t, 0, 1'b0);
    end

    // sweep of every kind and distance
    for (int t = 0; t < 4; t++) begin
      for (int n = 0; n < 32; n++) begin
        apply(32'h0000_0000, t, n, 1'b1);
        apply(32'hFFFF_FFFF, t, n, 1'b0);
        apply(32'h8000_0000, t, n, 1'b1);
        apply(32'h0000_0001, t, n, 1'b0);
        for (int k = 0; k < 6; k++) begin
          seed = next_rand(seed);
          apply(seed, t, n, seed[7]);
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule